// File: doc/BRIEF.md
# Daughterboard GPIO Source Mux with Radio-State Outputs

This block drives 32 general-purpose pins that are split into two halves. The upper sixteen pins belong to the transmit side and the lower sixteen to the receive side. Every pin has its own direction bit. When a pin is an output, a 2-bit code chosen per pin selects where its value comes from. The four sources are a software output register, a table indexed by the live radio state, and two debug buses.

The radio-state table holds one 32-bit word for each of four states: idle, transmit-only, receive-only and full-duplex. Each word carries a 16-bit value for the transmit side and a 16-bit value for the receive side. The state is taken from the `run_tx_i` and `run_rx_i` status inputs. Pins that act as inputs pass through a two-flop synchronizer, and the result can be read on the I/O register address.

Software reaches every register over a word-addressed bus. A write takes effect on the clock edge. A read is combinational from the address.

Top module: `gpio_atr_top`

## Requirements
- R1: While reset is held and just after it is released, every register is zero. `pad_oe_o` and `pad_out_o` are zero, and reading any address other than 0 returns zero.
- R2: A write updates exactly one register at the clock edge, and a read returns the full 32-bit register. Address 0 holds the software output value and address 1 the direction. Address 2 holds the transmit select fields and address 3 the receive select fields. Addresses 4, 5, 6 and 7 hold the state words for idle, transmit-only, receive-only and full-duplex. All registers keep their value when there is no write.
- R3: `pad_oe_o` equals the direction register. A 1 makes the pin an output. Bit 16+i is transmit pin i and bit i is receive pin i.
- R4: The select field for pin i of a side sits at bits 2i+1:2i of that side's select register. Code 0 drives the output from the matching bit of the software output register.
- R5: Code 1 drives the output from the state word chosen by {run_tx_i, run_rx_i}, sampled on the previous clock edge. 00 selects idle, 10 transmit-only, 01 receive-only and 11 full-duplex. Transmit pins use bits 15:0 of the word and receive pins use bits 31:16.
- R6: Code 2 drives the output from `dbg0_i` and code 3 from `dbg1_i`, using the same pin bit.
- R7: A pin whose direction bit is 0 drives `pad_out_o` low, whatever its select code.
- R8: Reading address 0 returns, for each pin, the driven value if the pin is an output. If the pin is an input, the read returns `pad_in_i` delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| run_tx_i | input | 1 | Transmitter active status |
| run_rx_i | input | 1 | Receiver active status |
| dbg0_i | input | 32 | Debug bus 0, one bit per pin |
| dbg1_i | input | 32 | Debug bus 1, one bit per pin |
| pad_in_i | input | 32 | Pin levels from the pads |
| pad_out_o | output | 32 | Pin output values to the pads |
| pad_oe_o | output | 32 | Pin output enables to the pads |

## Verification
The assertions take for granted that the bus inputs, the run status inputs and the pad inputs are synchronous to `clk_i`. They also assume that `bus_we_i` is never unknown. The stimulus changes every input only on the falling edge, so nothing moves near the sampling edge. Write data, select codes and direction bits are drawn at random, which exercises every source code on both halves. The run status inputs are held for several cycles at a time and then moved to a new state, so that each table word is reached.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_IO     = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR    = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEL_TX = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEL_RX = 3'd3;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_ATR  = 2'd1,
    SRC_DBG0 = 2'd2,
    SRC_DBG1 = 2'd3
  } src_sel_e;

  // encoded as {run_tx, run_rx}
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_RXONLY = 2'b01,
    ST_TXONLY = 2'b10,
    ST_FULL   = 2'b11
  } radio_st_e;

  localparam int N_STATES = 4;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_atr_pkg::*;
#(
  parameter int SIDE_W = 16,
  localparam int DATA_W = 2 * SIDE_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 io_o,
  output logic [DATA_W-1:0]                 dir_o,
  output logic [DATA_W-1:0]                 sel_tx_o,
  output logic [DATA_W-1:0]                 sel_rx_o,
  output logic [N_STATES-1:0][DATA_W-1:0]   atr_o
);
  logic [DATA_W-1:0]               io_q, dir_q, sel_tx_q, sel_rx_q;
  logic [N_STATES-1:0][DATA_W-1:0] atr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_q     <= '0;
      dir_q    <= '0;
      sel_tx_q <= '0;
      sel_rx_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_IO:     io_q     <= wdata_i;
        A_DIR:    dir_q    <= wdata_i;
        A_SEL_TX: sel_tx_q <= wdata_i;
        A_SEL_RX: sel_rx_q <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < N_STATES; s++) begin : g_atr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        atr_q[s] <= '0;
      else if (we_i && addr_i[ADDR_W-1] && (addr_i[1:0] == 2'(s)))
        atr_q[s] <= wdata_i;
    end
  end

  assign io_o     = io_q;
  assign dir_o    = dir_q;
  assign sel_tx_o = sel_tx_q;
  assign sel_rx_o = sel_rx_q;
  assign atr_o    = atr_q;

  // R2
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(io_q) && $stable(dir_q) && $stable(sel_tx_q)
               && $stable(sel_rx_q) && $stable(atr_q)));
endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
  import gpio_atr_pkg::*;
#(
  parameter int SIDE_W = 16,
  localparam int DATA_W = 2 * SIDE_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            run_tx_i,
  input  logic                            run_rx_i,
  input  logic [N_STATES-1:0][DATA_W-1:0] atr_i,
  output logic [SIDE_W-1:0]               atr_tx_o,
  output logic [SIDE_W-1:0]               atr_rx_o
);
  radio_st_e   state_q;
  logic [1:0]  word_idx;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= radio_st_e'({run_tx_i, run_rx_i});
  end

  // table order: idle, tx-only, rx-only, full
  always_comb begin
    unique case (state_q)
      ST_IDLE:   word_idx = 2'd0;
      ST_TXONLY: word_idx = 2'd1;
      ST_RXONLY: word_idx = 2'd2;
      default:   word_idx = 2'd3;
    endcase
  end

  assign word     = atr_i[word_idx];
  assign atr_tx_o = word[SIDE_W-1:0];
  assign atr_rx_o = word[DATA_W-1:SIDE_W];

  // R5
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable({run_tx_i, run_rx_i}) |=> $stable(state_q));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_atr_pkg::*;
#(
  parameter int SIDE_W = 16,
  localparam int DATA_W = 2 * SIDE_W
) (
  input  logic [DATA_W-1:0] io_i,
  input  logic [DATA_W-1:0] dir_i,
  input  logic [DATA_W-1:0] sel_tx_i,
  input  logic [DATA_W-1:0] sel_rx_i,
  input  logic [SIDE_W-1:0] atr_tx_i,
  input  logic [SIDE_W-1:0] atr_rx_i,
  input  logic [DATA_W-1:0] dbg0_i,
  input  logic [DATA_W-1:0] dbg1_i,
  output logic [DATA_W-1:0] out_o
);
  for (genvar p = 0; p < DATA_W; p++) begin : g_pin
    localparam int IDX = p % SIDE_W;
    src_sel_e sel;
    logic     atr_bit;
    logic     val;

    if (p >= SIDE_W) begin : g_tx
      assign sel     = src_sel_e'(sel_tx_i[2*IDX +: 2]);
      assign atr_bit = atr_tx_i[IDX];
    end else begin : g_rx
      assign sel     = src_sel_e'(sel_rx_i[2*IDX +: 2]);
      assign atr_bit = atr_rx_i[IDX];
    end

    always_comb begin
      unique case (sel)
        SRC_SW:   val = io_i[p];
        SRC_ATR:  val = atr_bit;
        SRC_DBG0: val = dbg0_i[p];
        default:  val = dbg1_i[p];
      endcase
    end

    assign out_o[p] = dir_i[p] & val;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_atr_top.sv
module gpio_atr_top
  import gpio_atr_pkg::*;
#(
  parameter int SIDE_W = 16,
  localparam int DATA_W = 2 * SIDE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              run_tx_i,
  input  logic              run_rx_i,
  input  logic [DATA_W-1:0] dbg0_i,
  input  logic [DATA_W-1:0] dbg1_i,
  input  logic [DATA_W-1:0] pad_in_i,
  output logic [DATA_W-1:0] pad_out_o,
  output logic [DATA_W-1:0] pad_oe_o
);
  logic [DATA_W-1:0]               io_r, dir_r, sel_tx_r, sel_rx_r, in_sync;
  logic [N_STATES-1:0][DATA_W-1:0] atr_r;
  logic [SIDE_W-1:0]               atr_tx, atr_rx;

  gpio_regfile #(.SIDE_W(SIDE_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .io_o     (io_r),
    .dir_o    (dir_r),
    .sel_tx_o (sel_tx_r),
    .sel_rx_o (sel_rx_r),
    .atr_o    (atr_r)
  );

  gpio_atr_ctrl #(.SIDE_W(SIDE_W)) u_atr (
    .clk_i, .rst_ni,
    .run_tx_i, .run_rx_i,
    .atr_i    (atr_r),
    .atr_tx_o (atr_tx),
    .atr_rx_o (atr_rx)
  );

  gpio_pin_mux #(.SIDE_W(SIDE_W)) u_mux (
    .io_i     (io_r),
    .dir_i    (dir_r),
    .sel_tx_i (sel_tx_r),
    .sel_rx_i (sel_rx_r),
    .atr_tx_i (atr_tx),
    .atr_rx_i (atr_rx),
    .dbg0_i, .dbg1_i,
    .out_o    (pad_out_o)
  );

  gpio_in_sync #(.W(DATA_W)) u_sync (
    .clk_i, .rst_ni,
    .d_i (pad_in_i),
    .q_o (in_sync)
  );

  assign pad_oe_o = dir_r;

  always_comb begin
    unique case (bus_addr_i)
      A_IO:     bus_rdata_o = (pad_oe_o & pad_out_o) | (~pad_oe_o & in_sync);
      A_DIR:    bus_rdata_o = dir_r;
      A_SEL_TX: bus_rdata_o = sel_tx_r;
      A_SEL_RX: bus_rdata_o = sel_rx_r;
      default:  bus_rdata_o = atr_r[bus_addr_i[1:0]];
    endcase
  end

  // R3
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == A_DIR) |=> $stable(pad_oe_o));

  // R7
  input_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);

  // R8
  sync_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pad_in_i) |=> ##1 ((bus_addr_i != A_IO) ||
      (((bus_rdata_o ^ $past(pad_in_i, 2)) & ~pad_oe_o) == '0)));
endmodule

// File: tb/sim_gpio_atr_top.sv
module sim_gpio_atr_top;
  localparam int CLK_P = 10;
  localparam int NCYC  = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        run_tx = 1'b0, run_rx = 1'b0;
  logic [31:0] dbg0 = '0, dbg1 = '0, pad_in = '0, pad_out, pad_oe;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_atr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .run_tx_i(run_tx),
    .run_rx_i(run_rx), .dbg0_i(dbg0), .dbg1_i(dbg1), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  // reference model
  logic [31:0] m_reg [8];
  int          m_word;
  logic [31:0] m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[k]) m_reg[k] = '0;
      m_word = 0; m_s1 = '0; m_s2 = '0;
    end else begin
      if (we) m_reg[addr] = wdata;
      m_word = (run_rx ? 2 : 0) + (run_tx ? 1 : 0);
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  function automatic logic exp_pin(int p, output int code);
    int idx = p % 16;
    logic [31:0] w = m_reg[4 + m_word];
    logic [31:0] sr = (p >= 16) ? m_reg[2] : m_reg[3];
    logic a = (p >= 16) ? w[idx] : w[16 + idx];
    code = int'(sr[2*idx +: 2]);
    if (!m_reg[1][p]) begin code = -1; return 1'b0; end
    case (code)
      0: return m_reg[0][p];
      1: return a;
      2: return dbg0[p];
      default: return dbg1[p];
    endcase
  endfunction

  task automatic check_all();
    logic [31:0] eo, erd;
    int bad = -1, bcode = 0;
    for (int p = 0; p < 32; p++) begin
      int c;
      eo[p] = exp_pin(p, c);
      if (eo[p] !== pad_out[p] && bad < 0) begin bad = p; bcode = c; end
    end
    // R3 direction to enables
    n_chk++;
    if (pad_oe !== m_reg[1]) begin
      n_fail++;
      $display("FAIL R3 pad_oe actual %h expected %h", pad_oe, m_reg[1]);
    end
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      case (bcode)
        -1: $display("FAIL R7 pin %0d out actual %h expected %h", bad, pad_out, eo);
        0:  $display("FAIL R4 pin %0d out actual %h expected %h", bad, pad_out, eo);
        1:  $display("FAIL R5 pin %0d out actual %h expected %h", bad, pad_out, eo);
        default: $display("FAIL R6 pin %0d out actual %h expected %h", bad, pad_out, eo);
      endcase
    end
    erd = (addr == 0) ? ((m_reg[1] & eo) | (~m_reg[1] & m_s2)) : m_reg[addr];
    n_chk++;
    if (rdata !== erd) begin
      n_fail++;
      if (addr == 0) $display("FAIL R8 rdata actual %h expected %h", rdata, erd);
      else           $display("FAIL R2 addr %0d rdata actual %h expected %h", addr, rdata, erd);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hold = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 1; a < 8; a++) begin
      addr = 3'(a);
      #1;
      n_chk++;
      if (rdata !== '0) begin n_fail++; $display("FAIL R1 addr %0d actual %h expected 0", a, rdata); end
    end
    n_chk++;
    if (pad_oe !== '0 || pad_out !== '0) begin
      n_fail++; $display("FAIL R1 pads actual %h/%h expected 0/0", pad_oe, pad_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_all();  // R1 just after release
    for (int c = 0; c < NCYC; c++) begin
      we    = ($urandom_range(0, 9) < 4);
      addr  = 3'($urandom_range(0, 7));
      wdata = $urandom();
      dbg0  = $urandom();
      dbg1  = $urandom();
      if ($urandom_range(0, 3) == 0) pad_in = $urandom();
      if (hold == 0) begin
        {run_tx, run_rx} = 2'($urandom_range(0, 3));
        hold = $urandom_range(1, 8);
      end else hold--;
      @(negedge clk);
      check_all();
    end
    finish_run();
  end
endmodule